// File: doc/BRIEF.md
# Bus Transaction Type Classifier

This block sits between the load/store side of a processor core and its bus master. It takes one memory request at a time and decides which form the request takes on the system bus. The choice is a four-beat burst, a single-beat transfer, an address-only operation, or local completion with nothing sent to the bus. The request carries an operation code, a byte count, a cache-inhibit attribute, a write-through attribute and a cache-enable flag. A configuration input controls whether gatable address-only operations are broadcast.

The decision is registered. A request is taken with a valid/ready handshake. The result appears the next cycle, either as a bus request that is held until the bus master acknowledges it, or as a one-cycle local-completion pulse. The encoding does not depend on whether the target is memory or I/O, because neither the block nor its ports make that distinction. Request sizes that cannot be encoded are reported as errors and are never issued.

Top module: `bc_classify`

## Requirements
- R1: A read or write that must go single-beat and has a byte count of 1, 2, 3, 4 or 8 is issued with `xfer_type_o` = 1 (single) and `beats_o` = 1. `size_code_o` equals the byte count for counts 1 to 4, and is 0 for 8 bytes.
- R2: A read or write is forced to single-beat when `req_inhibit_i` is high or when `cache_on_i` is low.
- R3: A write with `req_wthru_i` high is forced to single-beat. A read with `req_wthru_i` high, on a cacheable page with caches on, is issued as a burst.
- R4: A read or write that is not forced to single-beat, with a byte count of 1, 2, 3, 4, 8 or 32, is issued as a burst: `xfer_type_o` = 2, `beats_o` = 4, `size_code_o` = 0.
- R5: Opcode 3 (non-gatable address-only), or opcode 2 (gatable address-only) with `bcast_en_i` high, is issued with `xfer_type_o` = 3, `beats_o` = 0 and `size_code_o` = 0.
- R6: Opcode 2 with `bcast_en_i` low never raises `bus_req_o`. `local_done_o` pulses for exactly one cycle, in the cycle after acceptance, with `xfer_type_o` = 0 and `err_o` low.
- R7: A read or write whose byte count is not legal for the form it needs never raises `bus_req_o`. Legal counts are 1, 2, 3, 4 and 8 for single-beat, and those plus 32 for burst. Such a request gives a one-cycle `local_done_o` together with `err_o`, in the cycle after acceptance.
- R8: While `bus_req_o` is high and `bus_ack_i` is low, `bus_req_o`, `xfer_type_o`, `size_code_o` and `beats_o` stay unchanged. After the cycle in which the acknowledge is sampled, `bus_req_o` drops unless a new request is accepted.
- R9: After reset, `bus_req_o`, `local_done_o` and `err_o` are low and `req_ready_o` is high.
- R10: For opcodes 2 and 3, the byte count and the cache attributes have no effect on the result.
- R11: Opcode encoding: 0 read, 1 write, 2 gatable address-only, 3 non-gatable address-only. A request is accepted on a rising edge where `req_valid_i` and `req_ready_o` are both high. The result is visible in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_op_i | input | 2 | Operation code |
| req_size_i | input | SIZE_W (6) | Byte count of the access |
| req_inhibit_i | input | 1 | Cache-inhibited page |
| req_wthru_i | input | 1 | Write-through page |
| cache_on_i | input | 1 | Caches enabled |
| bcast_en_i | input | 1 | Broadcast enable for gatable address-only operations |
| bus_req_o | output | 1 | Transaction pending for the bus master |
| bus_ack_i | input | 1 | Bus master takes the transaction |
| xfer_type_o | output | 2 | 0 none, 1 single, 2 burst, 3 address-only |
| size_code_o | output | 3 | Transfer size code |
| beats_o | output | 3 | Number of data beats |
| local_done_o | output | 1 | Request completed locally (suppressed or error) |
| err_o | output | 1 | Illegal size; qualifies `local_done_o` |

## Verification
Two things can meet in one cycle: the release of a held bus transaction by `bus_ack_i`, and the acceptance of the next request, which may complete locally. The bench keeps `bus_ack_i` low for a random number of cycles and checks that the held fields do not move. It also offers requests directly behind local completions and issued transactions. Each result is compared against a bench model of the classification rules. Combinations that pit attribute priority against size legality, such as a 32-byte request on an inhibited page, are driven as directed cases.

// File: rtl/bc_pkg.sv
package bc_pkg;
  typedef enum logic [1:0] {
    OP_READ     = 2'd0,
    OP_WRITE    = 2'd1,
    OP_AO_GATED = 2'd2,
    OP_AO_FIXED = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    XT_NONE   = 2'd0,
    XT_SINGLE = 2'd1,
    XT_BURST  = 2'd2,
    XT_ADDR   = 2'd3
  } xfer_e;
endpackage

// File: rtl/bc_size_dec.sv
module bc_size_dec #(
  parameter int SIZE_W      = 6,
  parameter int BUS_BYTES   = 8,
  parameter int BLOCK_BYTES = 32,
  parameter int PART_MAX    = 4,
  parameter int CODE_W      = 3
) (
  input  logic [SIZE_W-1:0] size_i,
  output logic              single_ok_o,
  output logic              block_o,
  output logic [CODE_W-1:0] code_o
);
  logic [PART_MAX-1:0] part_hit;
  logic                full_bus;

  for (genvar k = 1; k <= PART_MAX; k++) begin : g_part
    assign part_hit[k-1] = (size_i == SIZE_W'(k));
  end

  assign full_bus    = (size_i == SIZE_W'(BUS_BYTES));
  assign block_o     = (size_i == SIZE_W'(BLOCK_BYTES));
  assign single_ok_o = (|part_hit) | full_bus;

  // partial widths encode their byte count, a full bus width encodes as zero
  always_comb begin
    code_o = '0;
    for (int k = 1; k <= PART_MAX; k++)
      if (part_hit[k-1]) code_o = CODE_W'(k);
  end
endmodule

// File: rtl/bc_type_sel.sv
module bc_type_sel
  import bc_pkg::*;
#(
  parameter int CODE_W = 3,
  parameter int BEAT_W = 3,
  parameter int BEATS  = 4
) (
  input  op_e               op_i,
  input  logic              single_ok_i,
  input  logic              block_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              inhibit_i,
  input  logic              wthru_i,
  input  logic              cache_on_i,
  input  logic              bcast_en_i,
  output xfer_e             xt_o,
  output logic [CODE_W-1:0] code_o,
  output logic [BEAT_W-1:0] beats_o,
  output logic              err_o
);
  logic force_single;

  assign force_single = inhibit_i | ~cache_on_i | ((op_i == OP_WRITE) & wthru_i);

  always_comb begin
    xt_o    = XT_NONE;
    code_o  = '0;
    beats_o = '0;
    err_o   = 1'b0;
    unique case (op_i)
      OP_AO_GATED: xt_o = bcast_en_i ? XT_ADDR : XT_NONE;
      OP_AO_FIXED: xt_o = XT_ADDR;
      default: begin
        if (force_single) begin
          if (single_ok_i) begin
            xt_o    = XT_SINGLE;
            code_o  = code_i;
            beats_o = BEAT_W'(1);
          end else begin
            err_o = 1'b1;
          end
        end else if (single_ok_i | block_i) begin
          xt_o    = XT_BURST;
          beats_o = BEAT_W'(BEATS);
        end else begin
          err_o = 1'b1;
        end
      end
    endcase
  end
endmodule

// File: rtl/bc_out_reg.sv
module bc_out_reg
  import bc_pkg::*;
#(
  parameter int CODE_W = 3,
  parameter int BEAT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  xfer_e             xt_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [BEAT_W-1:0] beats_i,
  input  logic              err_i,
  input  logic              bus_ack_i,
  output logic              free_o,
  output logic              bus_req_o,
  output logic              local_done_o,
  output logic              err_o,
  output xfer_e             xt_o,
  output logic [CODE_W-1:0] code_o,
  output logic [BEAT_W-1:0] beats_o
);
  logic vld_q, err_q;

  assign bus_req_o    = vld_q & (xt_o != XT_NONE);
  assign local_done_o = vld_q & (xt_o == XT_NONE);
  assign err_o        = vld_q & err_q;
  // local completions drain unconditionally, so a follower is taken in the same cycle
  assign free_o       = ~vld_q | local_done_o | (bus_req_o & bus_ack_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      err_q   <= 1'b0;
      xt_o    <= XT_NONE;
      code_o  <= '0;
      beats_o <= '0;
    end else if (load_i) begin
      vld_q   <= 1'b1;
      err_q   <= err_i;
      xt_o    <= xt_i;
      code_o  <= code_i;
      beats_o <= beats_i;
    end else if (free_o) begin
      vld_q <= 1'b0;
    end
  end
endmodule

// File: rtl/bc_classify.sv
module bc_classify
  import bc_pkg::*;
#(
  parameter int SIZE_W      = 6,
  parameter int BUS_BYTES   = 8,
  parameter int BLOCK_BYTES = 32,
  parameter int PART_MAX    = 4,
  parameter int CODE_W      = 3,
  localparam int BEATS      = BLOCK_BYTES / BUS_BYTES,
  localparam int BEAT_W     = $clog2(BEATS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_op_i,
  input  logic [SIZE_W-1:0] req_size_i,
  input  logic              req_inhibit_i,
  input  logic              req_wthru_i,
  input  logic              cache_on_i,
  input  logic              bcast_en_i,
  output logic              bus_req_o,
  input  logic              bus_ack_i,
  output logic [1:0]        xfer_type_o,
  output logic [CODE_W-1:0] size_code_o,
  output logic [BEAT_W-1:0] beats_o,
  output logic              local_done_o,
  output logic              err_o
);
  logic              single_ok, block;
  logic [CODE_W-1:0] dec_code, sel_code;
  logic [BEAT_W-1:0] sel_beats;
  logic              sel_err;
  xfer_e             sel_xt, out_xt;

  bc_size_dec #(
    .SIZE_W(SIZE_W), .BUS_BYTES(BUS_BYTES), .BLOCK_BYTES(BLOCK_BYTES),
    .PART_MAX(PART_MAX), .CODE_W(CODE_W)
  ) u_dec (
    .size_i(req_size_i), .single_ok_o(single_ok), .block_o(block), .code_o(dec_code)
  );

  bc_type_sel #(.CODE_W(CODE_W), .BEAT_W(BEAT_W), .BEATS(BEATS)) u_sel (
    .op_i(op_e'(req_op_i)), .single_ok_i(single_ok), .block_i(block), .code_i(dec_code),
    .inhibit_i(req_inhibit_i), .wthru_i(req_wthru_i), .cache_on_i(cache_on_i),
    .bcast_en_i(bcast_en_i), .xt_o(sel_xt), .code_o(sel_code), .beats_o(sel_beats),
    .err_o(sel_err)
  );

  bc_out_reg #(.CODE_W(CODE_W), .BEAT_W(BEAT_W)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(req_valid_i & req_ready_o),
    .xt_i(sel_xt), .code_i(sel_code), .beats_i(sel_beats), .err_i(sel_err),
    .bus_ack_i(bus_ack_i), .free_o(req_ready_o), .bus_req_o(bus_req_o),
    .local_done_o(local_done_o), .err_o(err_o), .xt_o(out_xt),
    .code_o(size_code_o), .beats_o(beats_o)
  );

  assign xfer_type_o = out_xt;
endmodule

// File: rtl/bc_classify_chk.sv
module bc_classify_chk #(
  parameter int CODE_W = 3,
  parameter int BEAT_W = 3,
  parameter int BEATS  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [1:0]        req_op_i,
  input logic              req_inhibit_i,
  input logic              cache_on_i,
  input logic              bcast_en_i,
  input logic              bus_req_o,
  input logic              bus_ack_i,
  input logic [1:0]        xfer_type_o,
  input logic [CODE_W-1:0] size_code_o,
  input logic [BEAT_W-1:0] beats_o,
  input logic              local_done_o,
  input logic              err_o
);
  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(xfer_type_o) &&
    $stable(size_code_o) && $stable(beats_o)); // R8
  AST_BURST_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && xfer_type_o == 2'd2 |-> beats_o == BEAT_W'(BEATS) && size_code_o == '0); // R4
  AST_ADDR_NO_BEATS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && xfer_type_o == 2'd3 |-> beats_o == '0); // R5
  AST_LOCAL_OFF_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    local_done_o |-> !bus_req_o); // R6
  AST_SUPPRESS_LOCAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && req_op_i == 2'd2 && !bcast_en_i |=>
    local_done_o && !err_o && !bus_req_o && xfer_type_o == 2'd0); // R6
  AST_FORCED_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && !req_op_i[1] && (req_inhibit_i || !cache_on_i) |=>
    (bus_req_o && xfer_type_o == 2'd1 && beats_o == BEAT_W'(1)) || err_o); // R2
  AST_ERR_NOT_ISSUED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> local_done_o && !bus_req_o); // R7
endmodule

bind bc_classify bc_classify_chk #(.CODE_W(CODE_W), .BEAT_W(BEAT_W), .BEATS(BEATS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .req_op_i(req_op_i), .req_inhibit_i(req_inhibit_i), .cache_on_i(cache_on_i),
  .bcast_en_i(bcast_en_i), .bus_req_o(bus_req_o), .bus_ack_i(bus_ack_i),
  .xfer_type_o(xfer_type_o), .size_code_o(size_code_o), .beats_o(beats_o),
  .local_done_o(local_done_o), .err_o(err_o)
);

// File: tb/bc_classify_test.sv
module bc_classify_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_ready;
  logic [1:0] req_op = '0;
  logic [5:0] req_size = '0;
  logic       inh = 1'b0, wt = 1'b0, con = 1'b1, bce = 1'b1;
  logic       bus_req, bus_ack = 1'b0, ldone, err;
  logic [1:0] xt;
  logic [2:0] code, beats;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bc_classify uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_size_i(req_size), .req_inhibit_i(inh), .req_wthru_i(wt),
    .cache_on_i(con), .bcast_en_i(bce), .bus_req_o(bus_req), .bus_ack_i(bus_ack),
    .xfer_type_o(xt), .size_code_o(code), .beats_o(beats), .local_done_o(ldone),
    .err_o(err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // model: returns {type, code, beats, err} and a requirement tag
  function automatic logic [8:0] model(input logic [1:0] op, input logic [5:0] sz,
      input logic i, input logic w, input logic c, input logic b, output string tag);
    logic       fs, legal1;
    logic [2:0] cd;
    legal1 = (sz >= 6'd1 && sz <= 6'd4) || sz == 6'd8;
    cd = (sz <= 6'd4) ? sz[2:0] : 3'd0;
    fs = i | ~c | (op == 2'd1 & w);
    if (op == 2'd2 && !b) begin tag = "R6"; return {2'd0, 3'd0, 3'd0, 1'b0}; end
    if (op[1])            begin tag = "R5"; return {2'd3, 3'd0, 3'd0, 1'b0}; end
    if (fs) begin
      tag = w && c && !i ? "R3" : (legal1 ? "R2" : "R7");
      if (legal1) return {2'd1, cd, 3'd1, 1'b0};
      return {2'd0, 3'd0, 3'd0, 1'b1};
    end
    tag = w ? "R3" : "R4";
    if (legal1 || sz == 6'd32) return {2'd2, 3'd0, 3'd4, 1'b0};
    tag = "R7";
    return {2'd0, 3'd0, 3'd0, 1'b1};
  endfunction

  task automatic send(input logic [1:0] op, input logic [5:0] sz, input logic i,
      input logic w, input logic c, input logic b, input int ack_wait);
    string      tag;
    logic [8:0] e;
    e = model(op, sz, i, w, c, b, tag);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_size = sz; inh = i; wt = w; con = c; bce = b;
    check({tag, " ready"}, 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R11 result"}, 32'({xt, code, beats, err}), 32'(e));
    if (e[8:7] != 2'd0) begin
      check({tag, " bus_req"}, 32'({bus_req, ldone}), 32'b10);
      for (int k = 0; k < ack_wait; k++) begin
        @(negedge clk);
        check("R8 hold", 32'({bus_req, xt, code, beats}), 32'({1'b1, e[8:1]}));
      end
      bus_ack = 1'b1;
      @(negedge clk);
      bus_ack = 1'b0;
      check("R8 release", 32'(bus_req), 32'd0);
    end else begin
      check({tag, " local"}, 32'({bus_req, ldone}), 32'b01);
      @(negedge clk);
      check({tag, " one-cycle"}, 32'({bus_req, ldone, err}), 32'd0);
    end
  endtask

  // back-to-back: local completion followed at once by another request
  task automatic pair_local_then_burst();
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd2; bce = 1'b0; req_size = 6'd9;
    @(negedge clk);
    check("R6 pair local", 32'({ldone, req_ready}), 32'b11);
    req_op = 2'd0; req_size = 6'd32; inh = 1'b0; con = 1'b1; wt = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    check("R4 pair burst", 32'({bus_req, ldone, xt, beats}), 32'({2'b10, 2'd2, 3'd4}));
    bus_ack = 1'b1;
    @(negedge clk);
    bus_ack = 1'b0;
    check("R8 pair release", 32'(bus_req), 32'd0);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (2) @(negedge clk);
    check("R9 reset", 32'({bus_req, ldone, err, req_ready}), 32'b0001);
    rst_n = 1'b1;
    // directed corners
    send(2'd0, 6'd3,  1'b1, 1'b0, 1'b1, 1'b1, 1); // R1 R2 3-byte inhibited
    send(2'd1, 6'd8,  1'b0, 1'b0, 1'b0, 1'b1, 0); // R2 caches off
    send(2'd1, 6'd4,  1'b0, 1'b1, 1'b1, 1'b1, 2); // R3 write-through store
    send(2'd0, 6'd32, 1'b0, 1'b1, 1'b1, 1'b1, 0); // R3 write-through read bursts
    send(2'd1, 6'd32, 1'b0, 1'b0, 1'b1, 1'b1, 3); // R4
    send(2'd0, 6'd32, 1'b1, 1'b0, 1'b1, 1'b1, 0); // R7 block on inhibited page
    send(2'd0, 6'd5,  1'b0, 1'b0, 1'b1, 1'b1, 0); // R7 bad size
    send(2'd2, 6'd0,  1'b1, 1'b0, 1'b0, 1'b1, 1); // R5 R10
    send(2'd3, 6'd63, 1'b0, 1'b1, 1'b1, 1'b0, 0); // R5 R10 fixed ignores enable
    send(2'd2, 6'd5,  1'b0, 1'b0, 1'b1, 1'b0, 0); // R6 R10
    pair_local_then_burst();
    for (int n = 0; n < 400; n++) begin
      logic [5:0] sz;
      case ($urandom_range(0, 3))
        0: sz = 6'($urandom_range(1, 4));
        1: sz = 6'd8;
        2: sz = 6'd32;
        default: sz = 6'($urandom_range(0, 63));
      endcase
      send(2'($urandom_range(0, 3)), sz, 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0),
           1'($urandom_range(0, 1)), $urandom_range(0, 3));
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule